// File: doc/BRIEF.md
# Broadcast-Row Partial-SAD Block Matcher

This block finds the sum of absolute differences (SAD) between a small square current block and every candidate position inside a reference search window. A grid of N×N processing elements is arranged as N rows. Each element keeps one pixel of the current block for the whole search. In each cycle one horizontal run of N reference pixels is presented to all element rows at once. Each element row reduces its N absolute differences to a single row total in a one-cycle adder tree. It adds that total to the running sum handed down from the row above and registers the result. The bottom row therefore yields one complete candidate SAD per cycle.

The search covers PH horizontal by PV vertical candidate positions. The window is PH+N-1 pixels wide and PV+N-1 rows tall. The candidates are scanned column by column, with the vertical offset advancing fastest. Reference data arrive on two row ports. Candidate columns with an even index use port 0 and those with an odd index use port 1. Feeding of a new column therefore starts on the idle port while the tail of the previous column is still being summed, and no bubble appears once the first result has come out. The current block is written row by row before the search. Each result leaves with a valid strobe and its displacement, and a one-cycle done pulse follows the last result. The block assumes PV ≥ N-1, so that the two streams sharing a port never overlap.

Top module: `sadp_array`

## Requirements
- R1: After a synchronous active-low reset, `out_vld` and `done` are 0 and stay 0 until a search is started.
- R2: The SAD reported for candidate (h,v) equals the sum over i,j in 0..N-1 of |cur[i][j] − win[v+i][h+j]|, where cur is the stored current block and win is the reference window.
- R3: Candidates are reported in the order (h=0,v=0), (0,1) … (0,PV-1), (1,0) … (PH-1,PV-1), and each result carries its h on `out_h` and its v on `out_v`.
- R4: `start` is sampled on a rising edge; call the cycle after that edge cycle 0. The j-th candidate in R3 order is valid in cycle N+j. PH·PV results appear in consecutive cycles with no gap, and `out_vld` is 0 in every other cycle.
- R5: In cycle h·PV+r, for r in 0..PV+N-2, reference row r of window column h is expected on port (h mod 2). Pixel j of a port word, in bits [8j+7:8j], is window column h+j. A port that has no assignment in a cycle is ignored.
- R6: `done` is high for exactly one cycle, cycle N+PH·PV, which is the cycle after the last valid result.
- R7: `start` is ignored from the cycle after an accepted start up to and including the cycle before `done`. A `start` in the `done` cycle itself is accepted.
- R8: A write with `cur_we`=1 stores `cur_data` as current-block row `cur_row`, with pixel j in bits [8j+7:8j]. A write made while a search is running, from the cycle after the accepted start through the cycle before `done`, is ignored and has no effect on any SAD.
- R9: The SAD output is 8+clog2(N·N) bits wide, so the largest possible value, N·N·255 (4080 for N=4), is reported exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_we | input | 1 | Current-block row write strobe |
| cur_row | input | clog2(N) | Index of the current-block row being written |
| cur_data | input | 8·N | Current-block row, pixel j in bits [8j+7:8j] |
| start | input | 1 | Start a search (sampled when idle) |
| ref0_data | input | 8·N | Reference row port for even search columns |
| ref1_data | input | 8·N | Reference row port for odd search columns |
| out_vld | output | 1 | A candidate SAD is valid this cycle |
| out_h | output | clog2(PH) | Horizontal displacement of the reported candidate |
| out_v | output | clog2(PV) | Vertical displacement of the reported candidate |
| out_sad | output | 8+clog2(N·N) | SAD of the reported candidate |
| done | output | 1 | One-cycle pulse after the last candidate |

## Verification
The bench aims at the column hand-over. In those cycles the upper element rows already sum the next column from the other port while the lower rows finish the current one. A design that selects the port per array rather than per row corrupts the last N-1 SADs of every column. It also fills the unassigned port with garbage, which a design would absorb into a SAD if it read the wrong port at the wrong time. Saturated pixels check that the output width holds 4080. A `start` pulse and a current-block write during a search must leave the result stream untouched, and a subsequent search must still use the original block. A `start` in the done cycle must launch a new search at once, which catches a busy flag that clears one cycle late.

// File: rtl/sadp_pkg.sv
// Shared pixel type and helper for the broadcast-row SAD array.
// Assumes unsigned 8-bit pixels throughout.
package sadp_pkg;
    localparam int PIX_W = 8;

    typedef logic [PIX_W-1:0] pix_t;

    // Absolute difference of two unsigned pixels.
    function automatic pix_t abs_diff(input pix_t a, input pix_t b);
        return (a > b) ? (a - b) : (b - a);
    endfunction
endpackage

// File: rtl/sadp_add_tree.sv
// Combinational balanced binary adder tree over N unsigned inputs.
// Inputs are padded with zeros to the next power of two, and the result is
// OUT_W bits wide, which the caller sizes so that the sum cannot overflow.
module sadp_add_tree #(
    parameter int N     = 4,
    parameter int IN_W  = 8,
    parameter int OUT_W = 10
) (
    input  logic [N*IN_W-1:0] in_flat,
    output logic [OUT_W-1:0]  sum
);
    localparam int LV = (N > 1) ? $clog2(N) : 0;
    localparam int M  = 1 << LV;

    logic [OUT_W-1:0] node [2*M-1];

    genvar k;
    generate
        // Leaves: real inputs, then zero padding.
        for (k = 0; k < M; k++) begin : g_leaf
            if (k < N) begin : g_in
                assign node[M-1+k] = OUT_W'(in_flat[k*IN_W +: IN_W]);
            end else begin : g_pad
                assign node[M-1+k] = '0;
            end
        end
        // Internal nodes: each one sums its two children.
        for (k = 0; k < M-1; k++) begin : g_node
            assign node[k] = node[2*k+1] + node[2*k+2];
        end
    endgenerate

    assign sum = node[0];
endmodule

// File: rtl/sadp_pe_row.sv
// One row of N processing elements. It holds one current-block row, takes
// the reference run from the port that belongs to the candidate column it
// is serving, reduces the N distortions to a row total and adds that to the
// partial SAD from the row above. The sum and the candidate tag are
// registered for the row below.
// Assumes that the candidate tag presented on in_* belongs to this row in
// this cycle.
module sadp_pe_row
    import sadp_pkg::*;
#(
    parameter int N     = 4,
    parameter int ROW   = 0,
    parameter int RIW   = 2,
    parameter int HW    = 2,
    parameter int VW    = 2,
    parameter int SAD_W = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 busy,
    input  logic                 cur_we,
    input  logic [RIW-1:0]       cur_row,
    input  logic [N*PIX_W-1:0]   cur_data,
    input  logic [N*PIX_W-1:0]   ref0_data,
    input  logic [N*PIX_W-1:0]   ref1_data,
    input  logic                 in_vld,
    input  logic [HW-1:0]        in_h,
    input  logic [VW-1:0]        in_v,
    input  logic [SAD_W-1:0]     in_psum,
    output logic                 out_vld,
    output logic [HW-1:0]        out_h,
    output logic [VW-1:0]        out_v,
    output logic [SAD_W-1:0]     out_psum
);
    localparam int RS_W = PIX_W + ((N > 1) ? $clog2(N) : 0);

    logic [N*PIX_W-1:0] cur_q;
    logic [N*PIX_W-1:0] ref_sel;
    logic [N*PIX_W-1:0] dist_flat;
    logic [RS_W-1:0]    row_sad;

    // Store this PE row's current pixels; writes are ignored during a search.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else if (cur_we && !busy && (cur_row == RIW'(ROW))) begin
            cur_q <= cur_data;
        end
    end

    // Port choice follows the parity of the candidate column served here.
    always_comb begin
        ref_sel = in_h[0] ? ref1_data : ref0_data;
    end

    genvar j;
    generate
        for (j = 0; j < N; j++) begin : g_pe
            // Distortion of PE j.
            assign dist_flat[j*PIX_W +: PIX_W] =
                abs_diff(cur_q[j*PIX_W +: PIX_W], ref_sel[j*PIX_W +: PIX_W]);
        end
    endgenerate

    sadp_add_tree #(
        .N     (N),
        .IN_W  (PIX_W),
        .OUT_W (RS_W)
    ) tree_i (
        .in_flat (dist_flat),
        .sum     (row_sad)
    );

    // Register the accumulated partial SAD and its tag for the next row down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_h    <= '0;
            out_v    <= '0;
            out_psum <= '0;
        end else begin
            out_vld  <= in_vld;
            out_h    <= in_h;
            out_v    <= in_v;
            out_psum <= in_psum + SAD_W'(row_sad);
        end
    end

    // R8
    cur_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cur_q));
endmodule

// File: rtl/sadp_scan_ctrl.sv
// Candidate range controller. On an accepted start it walks the vertical
// offset fastest and then the horizontal one, issuing one candidate tag per
// cycle for the top PE row. It stays busy until the last result leaves the
// array, then emits a one-cycle done pulse.
// Assumes last_seen pulses exactly once per search, when the final
// candidate leaves the bottom row.
module sadp_scan_ctrl #(
    parameter int PH = 4,
    parameter int PV = 4,
    parameter int HW = 2,
    parameter int VW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          last_seen,
    output logic          busy,
    output logic          gen_vld,
    output logic [HW-1:0] gen_h,
    output logic [VW-1:0] gen_v,
    output logic          done
);
    logic gen_end;

    always_comb begin
        gen_end = (gen_h == HW'(PH-1)) && (gen_v == VW'(PV-1));
    end

    // Search sequencing: accept start when idle, advance the scan counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            gen_vld <= 1'b0;
            gen_h   <= '0;
            gen_v   <= '0;
            done    <= 1'b0;
        end else begin
            done <= last_seen;
            if (!busy && start) begin
                busy    <= 1'b1;
                gen_vld <= 1'b1;
                gen_h   <= '0;
                gen_v   <= '0;
            end else begin
                if (last_seen) begin
                    busy <= 1'b0;
                end
                if (gen_vld) begin
                    if (gen_v == VW'(PV-1)) begin
                        gen_v <= '0;
                        if (gen_h == HW'(PH-1)) begin
                            gen_vld <= 1'b0;
                        end else begin
                            gen_h <= gen_h + 1'b1;
                        end
                    end else begin
                        gen_v <= gen_v + 1'b1;
                    end
                end
            end
        end
    end

    // R6
    done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !gen_vld) |=> !gen_vld);

    // R4
    gen_gapless_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_vld && !gen_end) |=> gen_vld);
endmodule

// File: rtl/sadp_array.sv
// Top of the broadcast-row partial-SAD block matcher. N PE rows form a
// vertical pipeline: row i serves candidate k-i in the cycle in which the
// scan controller issues candidate k, so the candidate tag simply travels
// down with the partial sum. Each row picks its reference port from the
// parity of its own candidate column.
// Assumes PV >= N-1, so that two columns sharing a port never overlap, and
// that the reference rows follow the schedule of R5.
module sadp_array
    import sadp_pkg::*;
#(
    parameter int N  = 4,
    parameter int PH = 4,
    parameter int PV = 4,
    localparam int RIW   = (N  > 1) ? $clog2(N)  : 1,
    localparam int HW    = (PH > 1) ? $clog2(PH) : 1,
    localparam int VW    = (PV > 1) ? $clog2(PV) : 1,
    localparam int SAD_W = PIX_W + ((N > 1) ? $clog2(N*N) : 0)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cur_we,
    input  logic [RIW-1:0]       cur_row,
    input  logic [N*PIX_W-1:0]   cur_data,
    input  logic                 start,
    input  logic [N*PIX_W-1:0]   ref0_data,
    input  logic [N*PIX_W-1:0]   ref1_data,
    output logic                 out_vld,
    output logic [HW-1:0]        out_h,
    output logic [VW-1:0]        out_v,
    output logic [SAD_W-1:0]     out_sad,
    output logic                 done
);
    logic             busy;
    logic             gen_vld;
    logic [HW-1:0]    gen_h;
    logic [VW-1:0]    gen_v;
    logic             out_last;

    logic             a_vld [N];
    logic [HW-1:0]    a_h   [N];
    logic [VW-1:0]    a_v   [N];
    logic [SAD_W-1:0] a_ps  [N];
    logic             s_vld [N];
    logic [HW-1:0]    s_h   [N];
    logic [VW-1:0]    s_v   [N];
    logic [SAD_W-1:0] s_ps  [N];

    sadp_scan_ctrl #(
        .PH (PH),
        .PV (PV),
        .HW (HW),
        .VW (VW)
    ) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .last_seen (out_last),
        .busy      (busy),
        .gen_vld   (gen_vld),
        .gen_h     (gen_h),
        .gen_v     (gen_v),
        .done      (done)
    );

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_row
            // Row inputs: the controller feeds the top row, the row above feeds the rest.
            if (i == 0) begin : g_top
                assign a_vld[i] = gen_vld;
                assign a_h[i]   = gen_h;
                assign a_v[i]   = gen_v;
                assign a_ps[i]  = '0;
            end else begin : g_mid
                assign a_vld[i] = s_vld[i-1];
                assign a_h[i]   = s_h[i-1];
                assign a_v[i]   = s_v[i-1];
                assign a_ps[i]  = s_ps[i-1];
            end

            sadp_pe_row #(
                .N     (N),
                .ROW   (i),
                .RIW   (RIW),
                .HW    (HW),
                .VW    (VW),
                .SAD_W (SAD_W)
            ) row_i (
                .clk       (clk),
                .rst_n     (rst_n),
                .busy      (busy),
                .cur_we    (cur_we),
                .cur_row   (cur_row),
                .cur_data  (cur_data),
                .ref0_data (ref0_data),
                .ref1_data (ref1_data),
                .in_vld    (a_vld[i]),
                .in_h      (a_h[i]),
                .in_v      (a_v[i]),
                .in_psum   (a_ps[i]),
                .out_vld   (s_vld[i]),
                .out_h     (s_h[i]),
                .out_v     (s_v[i]),
                .out_psum  (s_ps[i])
            );
        end

        // R5: rows that share a port in one cycle must serve the same column.
        for (i = 0; i < N; i++) begin : g_pa
            for (genvar jj = i + 1; jj < N; jj++) begin : g_pb
                port_share_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (a_vld[i] && a_vld[jj] && (a_h[i][0] == a_h[jj][0]))
                        |-> (a_h[i] == a_h[jj]));
            end
        end
    endgenerate

    // Bottom-row results go straight out.
    always_comb begin
        out_vld  = s_vld[N-1];
        out_h    = s_h[N-1];
        out_v    = s_v[N-1];
        out_sad  = s_ps[N-1];
        out_last = out_vld && (out_h == HW'(PH-1)) && (out_v == VW'(PV-1));
    end

    // R4
    out_gapless_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !out_last) |=> out_vld);

    // R6
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(out_last));

    // R3
    out_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && $past(out_vld) && !$past(out_last)) |->
            ((out_h == $past(out_h) && out_v == $past(out_v) + 1'b1) ||
             (out_v == '0 && out_h == $past(out_h) + 1'b1)));
endmodule

// File: tb/sadp_array_tb_top.sv
// Directed bench for sadp_array: a behavioural full-search model over a
// random window, with one task for each scenario.
module sadp_array_tb_top;
    localparam int N  = 4;
    localparam int PH = 4;
    localparam int PV = 4;
    localparam int WH = PH + N - 1;
    localparam int WV = PV + N - 1;
    localparam int NC = PH * PV;
    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cur_we = 1'b0;
    logic [1:0]    cur_row = '0;
    logic [N*8-1:0] cur_data = '0;
    logic          start = 1'b0;
    logic [N*8-1:0] ref0_data = '0;
    logic [N*8-1:0] ref1_data = '0;
    logic          out_vld;
    logic [1:0]    out_h;
    logic [1:0]    out_v;
    logic [11:0]   out_sad;
    logic          done;

    int cur_m [N][N];
    int win_m [WV][WH];
    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sadp_array #(.N(N), .PH(PH), .PV(PV)) dut_i (
        .clk(clk), .rst_n(rst_n), .cur_we(cur_we), .cur_row(cur_row),
        .cur_data(cur_data), .start(start), .ref0_data(ref0_data),
        .ref1_data(ref1_data), .out_vld(out_vld), .out_h(out_h),
        .out_v(out_v), .out_sad(out_sad), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("[TB] FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model_sad(input int h, input int v);
        int s = 0;
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                int d = cur_m[i][j] - win_m[v+i][h+j];
                s += (d < 0) ? -d : d;
            end
        return s;
    endfunction

    function automatic logic [N*8-1:0] win_word(input int r, input int h);
        logic [N*8-1:0] w;
        for (int j = 0; j < N; j++) w[j*8 +: 8] = 8'(win_m[r][h+j]);
        return w;
    endfunction

    // Drive the R5 schedule for cycle c on port p; unassigned ports get fill.
    function automatic logic [N*8-1:0] port_word(input int p, input int c, input bit junk);
        for (int h = p; h < PH; h += 2) begin
            int r = c - h * PV;
            if (r >= 0 && r <= PV + N - 2) return win_word(r, h);
        end
        return junk ? {$urandom(), $urandom()} : '0;
    endfunction

    task automatic load_cur();
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            cur_we  = 1'b1;
            cur_row = 2'(i);
            for (int j = 0; j < N; j++) cur_data[j*8 +: 8] = 8'(cur_m[i][j]);
        end
        @(negedge clk);
        cur_we = 1'b0;
    endtask

    task automatic fill_random();
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) cur_m[i][j] = $urandom_range(0, 255);
        for (int r = 0; r < WV; r++)
            for (int c = 0; c < WH; c++) win_m[r][c] = $urandom_range(0, 255);
    endtask

    // One search: cycle c is the c-th cycle after the start edge.
    task automatic run_scan(input bit skip_start, input bit junk, input bit poke,
                            input bit chain);
        int last_c;
        if (!skip_start) begin
            @(negedge clk);
            start = 1'b1;
        end
        @(posedge clk);
        last_c = chain ? N + NC : N + NC + N + 2;
        for (int c = 0; c <= last_c; c++) begin
            bit exp_v;
            int jx;
            @(negedge clk);
            start  = (poke && c == 3) ? 1'b1 : 1'b0;
            cur_we = (poke && c == 2) ? 1'b1 : 1'b0;
            if (poke && c == 2) begin
                cur_row  = 2'd1;
                cur_data = {$urandom(), $urandom()};
            end
            ref0_data = port_word(0, c, junk);
            ref1_data = port_word(1, c, junk);
            exp_v = (c >= N) && (c < N + NC);
            jx = c - N;
            check(out_vld === exp_v, "R4 out_vld", int'(out_vld), int'(exp_v));
            if (exp_v) begin
                int eh = jx / PV;
                int ev = jx % PV;
                int es = model_sad(eh, ev);
                check(out_h === 2'(eh) && out_v === 2'(ev), "R3 tag",
                      int'(out_h) * 16 + int'(out_v), eh * 16 + ev);
                check(out_sad === 12'(es), "R2 sad", int'(out_sad), es);
            end
            check(done === (c == N + NC), "R6 done", int'(done), int'(c == N + NC));
        end
        cur_we = 1'b0;
        if (chain) start = 1'b1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_vld === 1'b0 && done === 1'b0, "R1 reset", int'(out_vld) + 2 * int'(done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(out_vld === 1'b0 && done === 1'b0, "R1 idle", int'(out_vld) + 2 * int'(done), 0);
    endtask

    task automatic t_plain();
        fill_random();
        load_cur();
        run_scan(1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_idle_port_junk();   // R5: fill on the unassigned port is ignored
        fill_random();
        load_cur();
        run_scan(1'b0, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_saturate();          // R9: largest SAD 4080
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) cur_m[i][j] = 255;
        for (int r = 0; r < WV; r++)
            for (int c = 0; c < WH; c++) win_m[r][c] = 0;
        load_cur();
        check(model_sad(0, 0) == 4080, "R9 model", model_sad(0, 0), 4080);
        run_scan(1'b0, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_match();             // R2: exact match gives zero at (2,1)
        fill_random();
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) win_m[1+i][2+j] = cur_m[i][j];
        load_cur();
        check(model_sad(2, 1) == 0, "R2 model", model_sad(2, 1), 0);
        run_scan(1'b0, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_busy_ignore();       // R7 and R8: start and write during a search
        fill_random();
        load_cur();
        run_scan(1'b0, 1'b1, 1'b1, 1'b0);
        run_scan(1'b0, 1'b0, 1'b0, 1'b0); // the block must still hold the old rows
    endtask

    task automatic t_chain();             // R7: start in the done cycle is accepted
        fill_random();
        load_cur();
        run_scan(1'b0, 1'b1, 1'b0, 1'b1);
        run_scan(1'b1, 1'b1, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("[TB] FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_plain();
        t_idle_port_junk();
        t_saturate();
        t_match();
        t_busy_ignore();
        t_chain();
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule